// File: doc/BRIEF.md
# I/O Port Snoop Cache

This block watches the processor's I/O cycles and keeps the most recent byte seen on every port number. It has two tables, one for input cycles and one for output cycles, with one entry per port. Each entry holds the byte plus three flags. One flag says whether the port has been touched since the last wipe. One says whether the on-board logic served the cycle rather than a device out on the bus. The third, kept only in the input table, says whether the on-board handler's direction disagreed with the direction seen on the bus.

A host reads any entry through a registered read port and gets the result one cycle later. Wiping both tables happens after reset, or when the host pulses a clear request. A wipe walks every index of both tables, one index per clock. While it runs, the block raises `busy` and drops all snooped cycles.

Top module: `io_snoop_cache`

## Requirements
- R1: After synchronous reset is released, `busy` stays high for exactly 2^PORT_W cycles. After that, every entry of both tables reads value 0 with all three flags 0.
- R2: A snooped cycle with `snp_is_out`=0 (input) writes `snp_data` into the input-table entry at `snp_port` and sets its seen flag. The output-table entry at that port is left unchanged.
- R3: A snooped cycle with `snp_is_out`=1 (output) writes the output-table entry at `snp_port` and sets its seen flag. The input-table entry at that port is left unchanged.
- R4: A later cycle to the same port and direction replaces the value and all flags of that entry. Only the last byte is kept.
- R5: An entry's local flag equals the `snp_local` value of the cycle that last wrote it (1 = served on board, 0 = external bus device).
- R6: An input-table entry's mismatch flag is set only when `snp_local`=1 and `snp_local_is_out` is 1 while the snooped cycle was an input. Output-table entries always read mismatch 0.
- R7: A `clr_req` pulse while idle raises `busy` on the next cycle. Once `busy` falls, every entry of both tables reads zero with all flags clear.
- R8: Snooped cycles presented while `busy` is high change no entry.
- R9: A `clr_req` pulse while `busy` is already high is ignored. The wipe still lasts exactly 2^PORT_W cycles.
- R10: `rd_en` in one cycle produces `rd_valid` in the next cycle only. The data returned is the entry of the table picked by `rd_sel_out` (0 = input, 1 = output) at `rd_port`.
- R11: A read of an entry in the same cycle that a snooped cycle writes that entry returns the contents from before the write.
- R12: While `snp_valid` is 0, no entry changes, whatever the other snoop inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts a wipe |
| snp_valid | input | 1 | A snooped I/O cycle is present this clock |
| snp_port | input | PORT_W | Port number of the snooped cycle |
| snp_data | input | DATA_W | Byte carried by the snooped cycle |
| snp_is_out | input | 1 | Snooped direction: 0 input, 1 output |
| snp_local | input | 1 | On-board logic served this cycle |
| snp_local_is_out | input | 1 | Direction the on-board handler served: 0 input, 1 output |
| clr_req | input | 1 | Request to wipe both tables |
| busy | output | 1 | Wipe in progress; snoops are dropped |
| rd_en | input | 1 | Host read request |
| rd_sel_out | input | 1 | Table to read: 0 input, 1 output |
| rd_port | input | PORT_W | Entry to read |
| rd_valid | output | 1 | Read data valid (one cycle after `rd_en`) |
| rd_value | output | DATA_W | Last byte stored for the entry |
| rd_seen | output | 1 | Entry was written since the last wipe |
| rd_local | output | 1 | Entry was last written by an on-board-served cycle |
| rd_mismatch | output | 1 | Handler and snooped direction disagreed (input table) |

## Verification
The bench builds the block with PORT_W=4 and DATA_W=8, so each table has 16 entries. At that size a full wipe takes 16 cycles, and a complete dump of both tables takes 32 reads. Every wipe's exact length and its fully cleared result can therefore be checked end to end, including the lowest and highest port numbers and a clear request that lands in the middle of a sweep. Several complete dumps fit easily in the run.

// File: rtl/io_snoop_pkg.sv
package io_snoop_pkg;

    localparam int NUM_TABLES = 2;
    localparam int TBL_IN     = 0;
    localparam int TBL_OUT    = 1;

    typedef enum logic {
        DIR_IN  = 1'b0,
        DIR_OUT = 1'b1
    } io_dir_e;

    typedef struct packed {
        logic seen;
        logic local_srv;
        logic mismatch;
    } port_flags_t;

    // Flag set written by a snooped cycle into one table.
    function automatic port_flags_t build_flags(
        input logic in_table,
        input logic srv_local,
        input logic handler_out,
        input logic snoop_out
    );
        port_flags_t f;
        f.seen      = 1'b1;
        f.local_srv = srv_local;
        f.mismatch  = in_table & srv_local & (handler_out ^ snoop_out);
        return f;
    endfunction

endpackage

// File: rtl/io_snoop_sweep.sv
module io_snoop_sweep #(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              busy,
    output logic [PORT_W-1:0] idx
);
    localparam logic [PORT_W-1:0] LAST_IDX = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b1;
            idx  <= '0;
        end else if (busy) begin
            if (idx == LAST_IDX) begin
                busy <= 1'b0;
            end
            idx <= idx + 1'b1;
        end else if (start) begin
            busy <= 1'b1;
            idx  <= '0;
        end
    end

endmodule

// File: rtl/io_snoop_table.sv
module io_snoop_table
    import io_snoop_pkg::*;
#(
    parameter int PORT_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [PORT_W-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_val,
    input  port_flags_t       wr_flags,
    input  logic              clr_en,
    input  logic [PORT_W-1:0] clr_idx,
    input  logic              rd_en,
    input  logic [PORT_W-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_val,
    output port_flags_t       rd_flags
);
    localparam int DEPTH = 1 << PORT_W;
    localparam int FLG_W = $bits(port_flags_t);
    localparam int ENT_W = DATA_W + FLG_W;

    logic [ENT_W-1:0] mem [DEPTH];
    logic [ENT_W-1:0] rd_q;

    // Wipe has priority; the top also blocks writes while wiping.
    always_ff @(posedge clk) begin
        if (clr_en) begin
            mem[clr_idx] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= {wr_flags, wr_val};
        end
    end

    // Read returns the contents held before this edge's write.
    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_q <= mem[rd_idx];
        end
    end

    assign rd_val   = rd_q[DATA_W-1:0];
    assign rd_flags = port_flags_t'(rd_q[ENT_W-1:DATA_W]);

endmodule

// File: rtl/io_snoop_cache.sv
module io_snoop_cache
    import io_snoop_pkg::*;
#(
    parameter int PORT_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              snp_valid,
    input  logic [PORT_W-1:0] snp_port,
    input  logic [DATA_W-1:0] snp_data,
    input  logic              snp_is_out,
    input  logic              snp_local,
    input  logic              snp_local_is_out,
    input  logic              clr_req,
    output logic              busy,
    input  logic              rd_en,
    input  logic              rd_sel_out,
    input  logic [PORT_W-1:0] rd_port,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_value,
    output logic              rd_seen,
    output logic              rd_local,
    output logic              rd_mismatch
);
    logic              sweep_busy;
    logic [PORT_W-1:0] sweep_idx;
    logic              accept;
    logic              sel_q;

    logic [DATA_W-1:0] tbl_val [NUM_TABLES];
    port_flags_t       tbl_flg [NUM_TABLES];
    port_flags_t       out_flg;

    io_snoop_sweep #(.PORT_W(PORT_W)) u_sweep (
        .clk   (clk),
        .rst   (rst),
        .start (clr_req),
        .busy  (sweep_busy),
        .idx   (sweep_idx)
    );

    assign busy   = sweep_busy;
    assign accept = snp_valid & ~sweep_busy;

    for (genvar t = 0; t < NUM_TABLES; t++) begin : g_tbl
        localparam logic IS_OUT = (t == TBL_OUT);
        logic        wr_en_t;
        port_flags_t wr_flg_t;

        assign wr_en_t  = accept & (snp_is_out == IS_OUT);
        assign wr_flg_t = build_flags(~IS_OUT, snp_local, snp_local_is_out, snp_is_out);

        io_snoop_table #(.PORT_W(PORT_W), .DATA_W(DATA_W)) u_tbl (
            .clk      (clk),
            .wr_en    (wr_en_t),
            .wr_idx   (snp_port),
            .wr_val   (snp_data),
            .wr_flags (wr_flg_t),
            .clr_en   (sweep_busy),
            .clr_idx  (sweep_idx),
            .rd_en    (rd_en),
            .rd_idx   (rd_port),
            .rd_val   (tbl_val[t]),
            .rd_flags (tbl_flg[t])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            sel_q    <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                sel_q <= rd_sel_out;
            end
        end
    end

    always_comb begin
        rd_value = sel_q ? tbl_val[TBL_OUT] : tbl_val[TBL_IN];
        out_flg  = sel_q ? tbl_flg[TBL_OUT] : tbl_flg[TBL_IN];
    end

    assign rd_seen     = out_flg.seen;
    assign rd_local    = out_flg.local_srv;
    assign rd_mismatch = out_flg.mismatch;

endmodule

// File: rtl/io_snoop_cache_chk.sv
module io_snoop_cache_chk #(
    parameter int PORT_W = 8,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              clr_req,
    input logic              busy,
    input logic              rd_en,
    input logic              rd_sel_out,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_value,
    input logic              rd_seen,
    input logic              rd_local,
    input logic              rd_mismatch
);
    localparam int DEPTH = 1 << PORT_W;

    logic [PORT_W:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
        end else begin
            run_cnt <= busy ? run_cnt + 1'b1 : '0;
        end
    end

    AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid); // R10
    AST_RD_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid); // R10
    AST_CLR_STARTS: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !busy) |=> busy); // R7
    AST_SWEEP_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run_cnt < (PORT_W+1)'(DEPTH))); // R9
    AST_SWEEP_FULL: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (run_cnt == (PORT_W+1)'(DEPTH))); // R1
    AST_MISMATCH_LOCAL: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_mismatch) |-> (rd_local && rd_seen)); // R6
    AST_OUT_NO_MISMATCH: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && $past(rd_sel_out)) |-> !rd_mismatch); // R6
    AST_UNSEEN_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_seen) |-> (rd_value == '0 && !rd_local)); // R7

endmodule

bind io_snoop_cache io_snoop_cache_chk #(.PORT_W(PORT_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .clr_req     (clr_req),
    .busy        (busy),
    .rd_en       (rd_en),
    .rd_sel_out  (rd_sel_out),
    .rd_valid    (rd_valid),
    .rd_value    (rd_value),
    .rd_seen     (rd_seen),
    .rd_local    (rd_local),
    .rd_mismatch (rd_mismatch)
);

// File: tb/io_snoop_cache_tb.sv
module io_snoop_cache_tb;
    localparam int PW = 4;
    localparam int N  = 1 << PW;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          snp_valid = 1'b0;
    logic [PW-1:0] snp_port = '0;
    logic [DW-1:0] snp_data = '0;
    logic          snp_is_out = 1'b0;
    logic          snp_local = 1'b0;
    logic          snp_local_is_out = 1'b0;
    logic          clr_req = 1'b0;
    logic          busy;
    logic          rd_en = 1'b0;
    logic          rd_sel_out = 1'b0;
    logic [PW-1:0] rd_port = '0;
    logic          rd_valid;
    logic [DW-1:0] rd_value;
    logic          rd_seen, rd_local, rd_mismatch;

    io_snoop_cache #(.PORT_W(PW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst), .snp_valid(snp_valid), .snp_port(snp_port),
        .snp_data(snp_data), .snp_is_out(snp_is_out), .snp_local(snp_local),
        .snp_local_is_out(snp_local_is_out), .clr_req(clr_req), .busy(busy),
        .rd_en(rd_en), .rd_sel_out(rd_sel_out), .rd_port(rd_port),
        .rd_valid(rd_valid), .rd_value(rd_value), .rd_seen(rd_seen),
        .rd_local(rd_local), .rd_mismatch(rd_mismatch)
    );

    always #10 clk = ~clk;

    typedef struct {
        logic [DW-1:0] val;
        bit seen, loc, mis;
        int tbl, port;
        string tag;
    } exp_t;

    exp_t q[$];
    logic [DW-1:0] m_val  [2][N];
    bit            m_seen [2][N];
    bit            m_loc  [2][N];
    bit            m_mis  [2][N];
    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic zero_model();
        for (int t = 0; t < 2; t++)
            for (int p = 0; p < N; p++) begin
                m_val[t][p] = '0; m_seen[t][p] = 0; m_loc[t][p] = 0; m_mis[t][p] = 0;
            end
    endtask

    // Drive one snooped cycle; the model follows only if the block is idle.
    task automatic set_snoop(input int port, input int data, input bit is_out,
                             input bit loc, input bit hout);
        int t;
        snp_valid = 1'b1; snp_port = PW'(port); snp_data = DW'(data);
        snp_is_out = is_out; snp_local = loc; snp_local_is_out = hout;
        if (!busy) begin
            t = is_out ? 1 : 0;
            m_val[t][port]  = DW'(data);
            m_seen[t][port] = 1;
            m_loc[t][port]  = loc;
            m_mis[t][port]  = !is_out && loc && (hout != is_out);
        end
    endtask

    task automatic push_read(input int tbl, input int port, input string tag);
        exp_t e;
        rd_en = 1'b1; rd_sel_out = tbl[0]; rd_port = PW'(port);
        e.val = m_val[tbl][port]; e.seen = m_seen[tbl][port];
        e.loc = m_loc[tbl][port]; e.mis = m_mis[tbl][port];
        e.tbl = tbl; e.port = port; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic step();
        @(negedge clk);
        snp_valid = 1'b0; rd_en = 1'b0;
    endtask

    task automatic snoop(input int port, input int data, input bit is_out,
                         input bit loc, input bit hout);
        set_snoop(port, data, is_out, loc, hout);
        step();
    endtask

    task automatic read1(input int tbl, input int port, input string tag);
        push_read(tbl, port, tag);
        step();
        step();
    endtask

    task automatic dump(input string tag);
        for (int t = 0; t < 2; t++)
            for (int p = 0; p < N; p++) begin
                push_read(t, p, tag);
                step();
            end
        step();
        step();
    endtask

    // Counts negedges with busy high; optionally pokes a snoop and a clear mid-sweep.
    task automatic measure_busy(input bit poke, output int n);
        n = 0;
        while (busy) begin
            n++;
            if (poke && n == 3) set_snoop(4, 'hEE, 0, 1, 1); // R8: dropped
            if (poke && n == 5) clr_req = 1'b1;               // R9: ignored
            @(negedge clk);
            snp_valid = 1'b0;
            clr_req   = 1'b0;
            if (n > 4 * N) break;
        end
    endtask

    // Scoreboard monitor.
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (q.size() == 0) begin
                check(0, "R10", "rd_valid without request", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                n_checks++;
                if (rd_value !== e.val || rd_seen !== e.seen ||
                    rd_local !== e.loc || rd_mismatch !== e.mis) begin
                    n_fail++;
                    $display("FAIL %s: tbl %0d port %0d actual val=%02h seen=%0d loc=%0d mis=%0d expected val=%02h seen=%0d loc=%0d mis=%0d",
                             e.tag, e.tbl, e.port, rd_value, rd_seen, rd_local,
                             rd_mismatch, e.val, e.seen, e.loc, e.mis);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        int n;
        zero_model();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        measure_busy(0, n);
        check(n == N, "R1", "busy cycles after reset", n, N);
        dump("R1");

        // Input and output cycles land in their own tables.
        snoop(2, 'h5A, 0, 0, 0);
        read1(0, 2, "R2");
        read1(1, 2, "R2");
        snoop(2, 'hC3, 1, 1, 1);
        read1(1, 2, "R3");
        read1(0, 2, "R3");
        read1(1, 2, "R5");

        // Direction disagreement.
        snoop(7, 'h11, 0, 1, 1);
        snoop(8, 'h22, 0, 1, 0);
        snoop(9, 'h33, 1, 1, 0);
        read1(0, 7, "R6");
        read1(0, 8, "R6");
        read1(1, 9, "R6");

        // Overwrite keeps only the last cycle.
        snoop(2, 'h77, 0, 1, 0);
        snoop(7, 'h44, 0, 0, 0);
        read1(0, 2, "R4");
        read1(0, 7, "R4");
        read1(0, 7, "R5");

        // Boundary ports.
        snoop(0, 'h01, 0, 0, 0);
        snoop(N-1, 'hFE, 0, 1, 1);
        snoop(0, 'h80, 1, 0, 1);
        snoop(N-1, 'h7F, 1, 1, 1);
        dump("R2");

        // Inputs wiggling while snp_valid is low.
        for (int i = 0; i < 6; i++) begin
            snp_valid = 1'b0; snp_port = PW'(i); snp_data = DW'(8'hA0 + i);
            snp_is_out = i[0]; snp_local = 1'b1; snp_local_is_out = ~i[0];
            @(negedge clk);
        end
        dump("R12");

        // Read colliding with a write to the same entry.
        push_read(0, 3, "R11");
        set_snoop(3, 'hAA, 0, 0, 0);
        step();
        push_read(0, 3, "R11");
        step();
        step();
        step();

        // Clear with a dropped snoop and an ignored second request.
        clr_req = 1'b1;
        @(negedge clk);
        clr_req = 1'b0;
        measure_busy(1, n);
        check(n == N, "R9", "busy cycles with mid-sweep clear", n, N);
        zero_model();
        dump("R7");
        read1(0, 4, "R8");
        snoop(4, 'h5C, 0, 0, 0);
        read1(0, 4, "R8");

        repeat (3) @(negedge clk);
        check(q.size() == 0, "R10", "pending reads at end", q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule